// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Responder

This block is the slave end of a single-wire, open-drain bus. It over-samples the line with a fast system clock. A long low from the master counts as a bus reset, and the block answers it with a presence pulse. The block then takes in one ROM-level command. It can identify itself in three ways: it can shift out its 64-bit identifier, it can compare the identifier bit by bit against one the master sends, or it can take part in the bit-wise search arbitration that lets a master find every slave on a shared line. A second search variant admits only slaves that hold an unacknowledged interrupt.

The identifier is built in hardware. It starts with a fixed family byte, then the 48-bit serial number taken from an input, then an 8-bit CRC that the block computes over those 56 bits. When the ROM phase ends successfully, the block gives a one-cycle strobe. Logic behind it can then take over the line for memory commands. The block only drives a pull-down enable. The open-drain pad and the wired-AND line belong to the surrounding logic.

Top module: `owr_rom_responder`

## Requirements
- R1: After the line has been low for at least 480 µs and is then released, the block waits 30 µs and then asserts `pull_o` for exactly 120 µs (presence). This works from any state, including partway through a command or an identifier transfer, and the block then expects a new command.
- R2: A low of less than 480 µs is not treated as a reset and produces no presence pulse.
- R3: Command 0x33 (sent least significant bit first, sampled 30 µs after each falling edge) makes the block send 64 bits, least significant bit first. The order is family byte 0x04, then the 48-bit serial number, then the CRC. After the 64th bit the block leaves the line released.
- R4: The CRC is x^8 + x^5 + x^4 + 1 in bit-reflected serial form. The register starts at zero, and the 56 bits of family and serial enter in transmit order.
- R5: Command 0xCC ends the ROM phase right after the eighth command bit and strobes `rom_done_o`.
- R6: Command 0x55 is followed by 64 master-written bits. If all of them equal the identifier, `rom_done_o` strobes. Any differing bit sends the block back to waiting for a reset, silent and with no strobe.
- R7: Command 0xF0 runs 64 rounds of three slots each. In the first slot the block sends its identifier bit, in the second the complement of that bit, and in the third it reads the master's chosen bit. After round 64, `rom_done_o` strobes.
- R8: In a search, if the master's chosen bit differs from the block's bit, the block drops out. It leaves the line released in every later slot, and it gives no strobe until the next reset.
- R9: Command 0xEC behaves like 0xF0 when `irq_pend_i` is high at decode. Otherwise the block stays silent until the next reset.
- R10: Any other command code leaves the block silent. Commands that follow are ignored until the next reset.
- R11: A 0 is sent by asserting `pull_o` from the detected falling edge for 30 µs. A 1 is sent by leaving the line released. The block never pulls in a slot where it is receiving.
- R12: `rom_done_o` is a single-cycle pulse, given at most once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 1 | Raw level of the shared line (asynchronous) |
| irq_pend_i | input | 1 | An unacknowledged interrupt is pending |
| serial_i | input | 48 | Serial-number field of the identifier |
| pull_o | output | 1 | Pull-down enable for the open-drain pad |
| rom_done_o | output | 1 | One-cycle strobe: ROM phase complete |

## Verification
The assertions assume that the master does not start a new time slot until the block's 30 µs sample and hold window has ended. They also assume that `serial_i` and `irq_pend_i` stay steady while a command runs. The stimulus meets both. Every slot is 75 µs long with lows of 6 µs or 60 µs, resets are 500 µs lows, and the serial number and interrupt flag change only between resets. The line is formed in the bench as the wired-AND of the master's drive and `pull_o`, so the block sees its own pulls the way a real pad would return them.

// File: rtl/owr_pkg.sv
package owr_pkg;

  localparam int ID_BITS   = 64;
  localparam int DATA_BITS = 56;
  localparam int CMD_BITS  = 8;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_SRCH     = 8'hF0;
  localparam logic [7:0] CMD_SRCH_IRQ = 8'hEC;

  typedef enum logic [2:0] {
    R_IDLE,
    R_CMD,
    R_READ,
    R_MATCH,
    R_SRCH,
    R_MEM
  } rom_st_t;

  typedef enum logic [1:0] {
    L_OPEN,
    L_WAIT,
    L_PULSE,
    L_SETTLE
  } line_st_t;

endpackage

// File: rtl/owr_crc8.sv
module owr_crc8 #(
  parameter int N = 56
) (
  input  logic [N-1:0] data_i,
  output logic [7:0]   crc_o
);

  // one unrolled stage per input bit, register starts at zero
  logic [N:0][7:0] st;
  assign st[0] = 8'h00;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      logic fb;
      assign fb = st[i][0] ^ data_i[i];
      assign st[i+1] = {fb, st[i][7:5], st[i][4] ^ fb, st[i][3] ^ fb, st[i][2:1]};
    end
  endgenerate

  assign crc_o = st[N];

endmodule

// File: rtl/owr_line_if.sv
module owr_line_if
  import owr_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_i,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic rst_evt_o,
  output logic slot_done_o,
  output logic rx_bit_o
);

  localparam int TPU     = (CLK_HZ >= 2_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int RST_T   = 480 * TPU;
  localparam int WAIT_T  = 30 * TPU;
  localparam int PULSE_T = 120 * TPU;
  localparam int SAMP_T  = 30 * TPU;
  localparam int LW      = $clog2(RST_T + 1);
  localparam int CW      = $clog2(PULSE_T + 1);

  logic          s1, s2, prv;
  logic [LW-1:0] low_cnt;
  logic [CW-1:0] pcnt, scnt;
  logic          slot_act, pull_q;
  line_st_t      lst;
  logic          fall, rise;

  assign fall   = prv & ~s2;
  assign rise   = ~prv & s2;
  assign pull_o = pull_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1          <= 1'b1;
      s2          <= 1'b1;
      prv         <= 1'b1;
      low_cnt     <= '0;
      pcnt        <= '0;
      scnt        <= '0;
      slot_act    <= 1'b0;
      pull_q      <= 1'b0;
      lst         <= L_OPEN;
      rst_evt_o   <= 1'b0;
      slot_done_o <= 1'b0;
      rx_bit_o    <= 1'b0;
    end else begin
      s1          <= bus_i;
      s2          <= s1;
      prv         <= s2;
      rst_evt_o   <= 1'b0;
      slot_done_o <= 1'b0;

      if (!s2) begin
        if (low_cnt != LW'(RST_T)) low_cnt <= low_cnt + LW'(1);
      end else begin
        low_cnt <= '0;
      end

      if (rise && low_cnt == LW'(RST_T)) begin
        rst_evt_o <= 1'b1;
        lst       <= L_WAIT;
        pcnt      <= '0;
        slot_act  <= 1'b0;
        pull_q    <= 1'b0;
      end else begin
        case (lst)
          L_WAIT: begin
            if (pcnt == CW'(WAIT_T - 1)) begin
              lst    <= L_PULSE;
              pcnt   <= '0;
              pull_q <= 1'b1;
            end else begin
              pcnt <= pcnt + CW'(1);
            end
          end
          L_PULSE: begin
            if (pcnt == CW'(PULSE_T - 1)) begin
              lst    <= L_SETTLE;
              pcnt   <= '0;
              pull_q <= 1'b0;
            end else begin
              pcnt <= pcnt + CW'(1);
            end
          end
          L_SETTLE: begin
            if (s2) lst <= L_OPEN;
          end
          default: begin
            if (slot_act) begin
              if (scnt == CW'(SAMP_T - 1)) begin
                slot_act    <= 1'b0;
                pull_q      <= 1'b0;
                slot_done_o <= 1'b1;
                rx_bit_o    <= s2;
              end else begin
                scnt <= scnt + CW'(1);
              end
            end else if (fall) begin
              slot_act <= 1'b1;
              scnt     <= '0;
              pull_q   <= tx_en_i & ~tx_bit_i;
            end
          end
        endcase
      end
    end
  end

  // R11: a pull starts only for presence or for a requested zero bit
  assert_pull_source_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_o) |-> (lst == L_PULSE) || $past(tx_en_i && !tx_bit_i));

  // R1: a reset is recognised only as the line comes back high
  assert_reset_on_release_R1: assert property (@(posedge clk) disable iff (rst)
    rst_evt_o |-> $past(!prv) && !pull_o);

  // R11: one sample strobe per slot
  assert_single_sample_R11: assert property (@(posedge clk) disable iff (rst)
    slot_done_o |=> !slot_done_o);

endmodule

// File: rtl/owr_rom_fsm.sv
module owr_rom_fsm
  import owr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_evt_i,
  input  logic               slot_done_i,
  input  logic               rx_bit_i,
  input  logic               irq_pend_i,
  input  logic [ID_BITS-1:0] id_i,
  output logic               tx_en_o,
  output logic               tx_bit_o,
  output logic               rom_done_o
);

  localparam int IW = $clog2(ID_BITS);

  rom_st_t            st;
  logic [IW-1:0]      cnt;
  logic [1:0]         ph;
  logic [CMD_BITS-1:0] cmd_sr, cmd_nx;
  logic               cur_bit;

  assign cur_bit  = id_i[cnt];
  assign cmd_nx   = {rx_bit_i, cmd_sr[CMD_BITS-1:1]};
  assign tx_en_o  = (st == R_READ) || (st == R_SRCH && ph != 2'd2);
  assign tx_bit_o = (st == R_SRCH && ph == 2'd1) ? ~cur_bit : cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= R_IDLE;
      cnt        <= '0;
      ph         <= '0;
      cmd_sr     <= '0;
      rom_done_o <= 1'b0;
    end else begin
      rom_done_o <= 1'b0;
      if (rst_evt_i) begin
        st  <= R_CMD;
        cnt <= '0;
        ph  <= '0;
      end else if (slot_done_i) begin
        case (st)
          R_CMD: begin
            cmd_sr <= cmd_nx;
            if (cnt == IW'(CMD_BITS - 1)) begin
              cnt <= '0;
              ph  <= '0;
              case (cmd_nx)
                CMD_READ:     st <= R_READ;
                CMD_MATCH:    st <= R_MATCH;
                CMD_SRCH:     st <= R_SRCH;
                CMD_SRCH_IRQ: st <= irq_pend_i ? R_SRCH : R_IDLE;
                CMD_SKIP: begin
                  st         <= R_MEM;
                  rom_done_o <= 1'b1;
                end
                default:      st <= R_IDLE;
              endcase
            end else begin
              cnt <= cnt + IW'(1);
            end
          end
          R_READ: begin
            if (cnt == IW'(ID_BITS - 1)) begin
              st         <= R_MEM;
              rom_done_o <= 1'b1;
            end else begin
              cnt <= cnt + IW'(1);
            end
          end
          R_MATCH: begin
            if (rx_bit_i != cur_bit) begin
              st <= R_IDLE;
            end else if (cnt == IW'(ID_BITS - 1)) begin
              st         <= R_MEM;
              rom_done_o <= 1'b1;
            end else begin
              cnt <= cnt + IW'(1);
            end
          end
          R_SRCH: begin
            if (ph != 2'd2) begin
              ph <= ph + 2'd1;
            end else if (rx_bit_i != cur_bit) begin
              st <= R_IDLE;
            end else if (cnt == IW'(ID_BITS - 1)) begin
              st         <= R_MEM;
              rom_done_o <= 1'b1;
            end else begin
              cnt <= cnt + IW'(1);
              ph  <= 2'd0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: completion strobe lasts a single cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rom_done_o |=> !rom_done_o);

  // R8: a mismatching master choice ends participation
  assert_search_dropout_R8: assert property (@(posedge clk) disable iff (rst)
    (st == R_SRCH && ph == 2'd2 && slot_done_i && !rst_evt_i && rx_bit_i != cur_bit)
    |=> st == R_IDLE && !tx_en_o);

  // R5: skip command finishes the ROM phase on its last bit
  assert_skip_done_R5: assert property (@(posedge clk) disable iff (rst)
    (st == R_CMD && slot_done_i && !rst_evt_i && cnt == IW'(CMD_BITS - 1) && cmd_nx == CMD_SKIP)
    |=> rom_done_o);

  // R10: an unknown code leaves the responder silent
  assert_unknown_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (st == R_CMD && slot_done_i && !rst_evt_i && cnt == IW'(CMD_BITS - 1) &&
     cmd_nx != CMD_READ && cmd_nx != CMD_MATCH && cmd_nx != CMD_SKIP &&
     cmd_nx != CMD_SRCH && cmd_nx != CMD_SRCH_IRQ)
    |=> !tx_en_o && !rom_done_o);

endmodule

// File: rtl/owr_rom_responder.sv
module owr_rom_responder
  import owr_pkg::*;
#(
  parameter int         CLK_HZ = 50_000_000,
  parameter logic [7:0] FAMILY = 8'h04
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_i,
  input  logic        irq_pend_i,
  input  logic [47:0] serial_i,
  output logic        pull_o,
  output logic        rom_done_o
);

  logic [DATA_BITS-1:0] id_data;
  logic [7:0]           crc;
  logic [ID_BITS-1:0]   id_q;
  logic                 tx_en, tx_bit, rst_evt, slot_done, rx_bit;

  assign id_data = {serial_i, FAMILY};

  owr_crc8 #(.N(DATA_BITS)) u_crc (
    .data_i (id_data),
    .crc_o  (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) id_q <= '0;
    else     id_q <= {crc, id_data};
  end

  owr_line_if #(.CLK_HZ(CLK_HZ)) u_line (
    .clk         (clk),
    .rst         (rst),
    .bus_i       (bus_i),
    .tx_en_i     (tx_en),
    .tx_bit_i    (tx_bit),
    .pull_o      (pull_o),
    .rst_evt_o   (rst_evt),
    .slot_done_o (slot_done),
    .rx_bit_o    (rx_bit)
  );

  owr_rom_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rst_evt_i   (rst_evt),
    .slot_done_i (slot_done),
    .rx_bit_i    (rx_bit),
    .irq_pend_i  (irq_pend_i),
    .id_i        (id_q),
    .tx_en_o     (tx_en),
    .tx_bit_o    (tx_bit),
    .rom_done_o  (rom_done_o)
  );

endmodule

// File: tb/sim_owr_rom_responder.sv
`timescale 1ns/1ps
module sim_owr_rom_responder;

  // one clock tick stands for one microsecond to keep runs short
  localparam int CLK_HZ = 1_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_low = 1'b0;
  logic        irq = 1'b0;
  logic [47:0] serial = 48'h5A3C_9E17_B2D4;
  logic        pull, done;
  wire         bus_w;

  assign bus_w = ~(master_low | pull);

  owr_rom_responder #(.CLK_HZ(CLK_HZ)) u0 (
    .clk        (clk),
    .rst        (rst),
    .bus_i      (bus_w),
    .irq_pend_i (irq),
    .serial_i   (serial),
    .pull_o     (pull),
    .rom_done_o (done)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int quiet_viol = 0;
  logic quiet = 1'b0;

  // per-clock comparison with the expected bus behaviour
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (quiet && pull) quiet_viol++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_id(input logic [47:0] s);
    logic [55:0] d;
    logic [7:0]  c;
    d = {s, 8'h04};
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic m;
      m = c[0] ^ d[i];
      c = {1'b0, c[7:1]} ^ (m ? 8'h8C : 8'h00);
    end
    return {c, d};
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input string req);
    int   pc;
    logic low70;
    quiet = 1'b0;
    master_low = 1'b1;
    ticks(500);
    master_low = 1'b0;
    pc = 0;
    low70 = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pull) pc++;
      if (i == 70) low70 = ~bus_w;
    end
    chk(req, "presence length", pc, 120);
    chk(req, "line low 70us after release", low70, 1);
  endtask

  task automatic wr_bit(input logic b);
    master_low = 1'b1;
    ticks(b ? 6 : 60);
    master_low = 1'b0;
    ticks(b ? 69 : 15);
  endtask

  task automatic rd_bit(output logic r);
    master_low = 1'b1;
    ticks(6);
    master_low = 1'b0;
    ticks(9);
    r = bus_w;
    ticks(60);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  // full search following the block's own bits; returns count of bad slots
  task automatic search_all(input logic [63:0] id, output int bad);
    logic a, b;
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd_bit(a);
      rd_bit(b);
      if (a !== id[i] || b !== ~id[i]) bad++;
      wr_bit(id[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=sequence end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] id, got;
    logic        r;
    int          bad, d0;

    ticks(10);
    rst = 1'b0;
    ticks(5);
    chk("R1", "pull after reset", pull, 0);
    chk("R12", "done after reset", done, 0);

    // R2: short low is not a reset
    master_low = 1'b1;
    ticks(400);
    master_low = 1'b0;
    d0 = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pull) d0++;
    end
    chk("R2", "pull cycles after short low", d0, 0);

    // R3/R4/R11: read identifier
    id = ref_id(serial);
    do_reset("R1");
    quiet = 1'b1;
    wr_byte(8'h33);
    quiet = 1'b0;
    done_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      rd_bit(r);
      got[i] = r;
    end
    chk("R3", "family byte", got[7:0], 8'h04);
    chk("R3", "serial field", got[55:8], serial);
    chk("R4", "crc byte", got[63:56], id[63:56]);
    chk("R12", "done pulses after read", done_cnt, 1);
    quiet = 1'b1;
    rd_bit(r);
    chk("R3", "line released after 64 bits", r, 1);
    chk("R11", "pulls while receiving", quiet_viol, 0);

    // R4: a second serial pattern
    serial = 48'hFFFF_0000_8001;
    id = ref_id(serial);
    do_reset("R1");
    quiet = 1'b1;
    wr_byte(8'h33);
    quiet = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rd_bit(r);
      got[i] = r;
    end
    chk("R4", "identifier with second serial", got, id);

    // R1: reset in the middle of a read, then skip
    do_reset("R1");
    wr_byte(8'h33);
    for (int i = 0; i < 20; i++) rd_bit(r);
    do_reset("R1");
    done_cnt = 0;
    quiet_viol = 0;
    quiet = 1'b1;
    wr_byte(8'hCC);
    chk("R5", "done after skip", done_cnt, 1);
    chk("R1", "pulls after mid-read reset", quiet_viol, 0);

    // R6: match with the right and a wrong identifier
    do_reset("R1");
    done_cnt = 0;
    quiet = 1'b1;
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(id[i]);
    chk("R6", "done after exact match", done_cnt, 1);
    do_reset("R1");
    done_cnt = 0;
    quiet_viol = 0;
    quiet = 1'b1;
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(i == 20 ? ~id[i] : id[i]);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      rd_bit(r);
      if (r !== 1'b1) bad++;
    end
    chk("R6", "done after mismatched match", done_cnt, 0);
    chk("R6", "pulled slots after mismatch", bad + quiet_viol, 0);

    // R7: normal search
    do_reset("R1");
    done_cnt = 0;
    wr_byte(8'hF0);
    search_all(id, bad);
    chk("R7", "search bit/complement errors", bad, 0);
    chk("R7", "done after search", done_cnt, 1);

    // R8: drop out on a wrong master choice
    do_reset("R1");
    done_cnt = 0;
    wr_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      rd_bit(r);
      rd_bit(r);
      wr_bit(i == 10 ? ~id[i] : id[i]);
    end
    quiet_viol = 0;
    quiet = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      rd_bit(r);
      if (r !== 1'b1) bad++;
      rd_bit(r);
      if (r !== 1'b1) bad++;
      wr_bit(id[i+11]);
    end
    chk("R8", "pulled slots after dropout", bad + quiet_viol, 0);
    chk("R8", "done after dropout", done_cnt, 0);

    // R9: interrupt-filtered search
    irq = 1'b0;
    do_reset("R1");
    quiet_viol = 0;
    quiet = 1'b1;
    wr_byte(8'hEC);
    rd_bit(r);
    got[0] = r;
    rd_bit(r);
    got[1] = r;
    chk("R9", "slots without pending interrupt", got[1:0], 2'b11);
    chk("R9", "pulls without pending interrupt", quiet_viol, 0);
    irq = 1'b1;
    do_reset("R1");
    done_cnt = 0;
    wr_byte(8'hEC);
    search_all(id, bad);
    chk("R9", "search errors with interrupt", bad, 0);
    chk("R9", "done with interrupt", done_cnt, 1);
    irq = 1'b0;

    // R10: unknown command, then recovery
    do_reset("R1");
    done_cnt = 0;
    quiet_viol = 0;
    quiet = 1'b1;
    wr_byte(8'hA5);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      rd_bit(r);
      if (r !== 1'b1) bad++;
    end
    wr_byte(8'hCC);
    chk("R10", "pulled slots after unknown code", bad + quiet_viol, 0);
    chk("R10", "done after unknown code", done_cnt, 0);
    do_reset("R1");
    wr_byte(8'hCC);
    chk("R12", "done once after recovery", done_cnt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule